// File: doc/BRIEF.md
# Descriptor-List DMA Channel Sequencer

This block is the control side of one DMA channel. Software programs a small register file, then sets the channel enable. The channel runs a transfer in one of three ways. In direct mode it runs once from source, destination and count registers that software writes itself. In single-pass list mode it walks a list of 16-byte descriptors in memory once. In endless list mode it walks the list and wraps from the last entry back to the first without stopping.

For each list entry the channel reads three words over a simple request/valid memory port. It loads them into its working registers, pulses a start strobe to an external data mover, and waits for that mover's done pulse before it goes on to the next entry. A hardware-maintained current-entry index can be read back at any time. A reprogrammable stage register lets software be told when a chosen entry finishes. This lets a ring buffer be serviced without stopping the channel.

The channel raises an interrupt from two flags, each with its own enable. Both flags are cleared by software writing them back as zero.

Top module: `dlist_dma_seq`

## Requirements
- R1: After reset every register reads zero, and `irq`, `memReq` and `mvStart` are low.
- R2: Register map by `regAddr` word index: 0 source, 1 destination, 2 count (only the low CNT_W bits are kept), 3 list base, 4 list control, 5 stage, 6 channel control. In the channel-control register, bit 0 is enable, bit 1 is the end flag, bit 2 the end-interrupt enable, bit 3 the stage flag, bit 4 the stage-interrupt enable, bits 7:5 the reload enables for count, destination and source (bit 5 = source, bit 6 = destination, bit 7 = count), bit 8 the list enable, and bits 10:9 the mode (01 single pass, 10 endless, 00 and 11 direct). In a direct run the mover receives the source, destination and count registers unchanged in one start pulse. When it finishes, the end flag is set and the enable clears in the same cycle.
- R3: Entry i of the list is fetched as three reads at base + 16*i + 0, + 4 and + 8, in that order. The fourth word is never read. The list-base register keeps address bits 31:4 and a list-select bit in bit 0, and reads bits 3:1 as zero.
- R4: In single-pass mode the channel issues one start per entry, from index 0 to the last index. The end flag is raised only after the last entry completes. The enable then clears, and the current index reads the last index. The list-control register holds the last index (entry count minus one) in bits 31:24 and reports the current index in bits 23:16.
- R5: In endless mode the index wraps from the last entry back to 0, the channel keeps running, and the end flag is never set.
- R6: When the entry whose index equals the stage register (bits 7:0) completes, the stage flag is set. This happens only in list modes.
- R7: `irq` is high exactly when (end flag and end-interrupt enable) or (stage flag and stage-interrupt enable).
- R8: Writing 1 to either flag has no effect, and writing 0 clears it. Clearing the stage flag while the enable stays 1 does not stop the channel.
- R9: Writing the enable to 0 halts the channel. No memory request and no start pulse follow, and a late done pulse is ignored.
- R10: In list mode, a word whose reload enable is 0 is not loaded. The register keeps its value and the mover receives it.
- R11: List operation needs mode 01 or 10, the list enable and the list-select bit all set. Otherwise the channel performs a direct run and makes no memory requests.
- R12: Writing list control with bit 15 set while the channel is disabled zeroes the current index. Written bits 23:16 are ignored.
- R13: `mvStart` is a one-cycle pulse, never high together with `memReq`, and only one mover operation is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register word index |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data (combinational from regAddr) |
| memReq | output | 1 | Descriptor word read request, held until memRvalid |
| memAddr | output | 32 | Byte address of the requested word |
| memRdata | input | 32 | Returned word |
| memRvalid | input | 1 | One-cycle response to the pending request |
| mvStart | output | 1 | Start pulse to the data mover |
| mvSrc | output | 32 | Source address for the mover |
| mvDst | output | 32 | Destination address for the mover |
| mvCount | output | CNT_W | Transfer count in units |
| mvDone | input | 1 | Mover completion pulse |
| irq | output | 1 | Channel interrupt |

## Verification
The assertions take for granted that `memRvalid` comes as a single pulse only while a request is pending, and that `mvDone` arrives only after a start and once per start. They also take for granted that software does not rewrite the list base, list control or mode while the channel is enabled. The bench's memory model answers each request exactly once, one cycle after it sees the request. Its mover model raises done a fixed few cycles after each start. The bench reprograms the list only between runs, after the enable reads back low. The single exception is the halt itself, and a late done after a halt is one of the cases the bench exercises.

// File: rtl/dlseq_pkg.sv
`timescale 1ns/1ps
package dlseq_pkg;

  typedef enum logic [1:0] {
    MODE_DIRECT  = 2'b00,
    MODE_ONCE    = 2'b01,
    MODE_ENDLESS = 2'b10,
    MODE_SPARE   = 2'b11
  } runMode_e;

  localparam logic [2:0] ADDR_SRC   = 3'd0;
  localparam logic [2:0] ADDR_DST   = 3'd1;
  localparam logic [2:0] ADDR_CNT   = 3'd2;
  localparam logic [2:0] ADDR_LBASE = 3'd3;
  localparam logic [2:0] ADDR_LCTRL = 3'd4;
  localparam logic [2:0] ADDR_STAGE = 3'd5;
  localparam logic [2:0] ADDR_CHCTL = 3'd6;

  localparam int WORDS_PER_ENTRY = 3;
  localparam int PTR_RESET_BIT   = 15;

  // strobes from the sequencer to the register datapath
  typedef struct packed {
    logic [WORDS_PER_ENTRY-1:0] loadVec;
    logic                       idxStep;
    logic                       idxWrap;
    logic                       setXferEnd;
    logic                       setStageEnd;
    logic [1:0]                 wordSel;
  } seqStrobe_t;

endpackage

// File: rtl/dlseq_regs.sv
`timescale 1ns/1ps
module dlseq_regs
  import dlseq_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int CNT_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [2:0]        regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  seqStrobe_t        strobe,
  input  logic [31:0]       memRdata,
  output logic [31:0]       memAddr,
  output logic [31:0]       mvSrc,
  output logic [31:0]       mvDst,
  output logic [CNT_W-1:0]  mvCount,
  output logic              chanEn,
  output logic              xferEndFlag,
  output logic              stageEndFlag,
  output logic              listMode,
  output logic              listEndless,
  output logic              atLast,
  output logic              atStage,
  output logic              irq
);

  localparam logic [31:0] CNT_MASK = 32'((64'd1 << CNT_W) - 64'd1);

  logic [2:0][31:0]  wordVal;
  logic [27:0]       baseHi;
  logic              baseSel;
  logic [IDX_W-1:0]  lastIdx;
  logic [IDX_W-1:0]  curIdx;
  logic [IDX_W-1:0]  stageIdx;
  logic              irqEn;
  logic              stageIrqEn;
  logic [2:0]        reloadEn;
  logic              listEn;
  runMode_e          modeSel;

  logic wrCtl, wrLctl, wrBase, wrStage;
  assign wrCtl   = regWrEn && (regAddr == ADDR_CHCTL);
  assign wrLctl  = regWrEn && (regAddr == ADDR_LCTRL);
  assign wrBase  = regWrEn && (regAddr == ADDR_LBASE);
  assign wrStage = regWrEn && (regAddr == ADDR_STAGE);

  // working words: written by software or reloaded from a fetched entry
  for (genvar w = 0; w < WORDS_PER_ENTRY; w++) begin : g_word
    localparam logic [31:0] KEEP = (w == 2) ? CNT_MASK : 32'hFFFF_FFFF;
    logic [31:0] held;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        held <= '0;
      end else if (strobe.loadVec[w] && reloadEn[w]) begin
        held <= memRdata & KEEP;
      end else if (regWrEn && (regAddr == 3'(w))) begin
        held <= regWrData & KEEP;
      end
    end
    assign wordVal[w] = held;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseHi   <= '0;
      baseSel  <= 1'b0;
      lastIdx  <= '0;
      stageIdx <= '0;
    end else begin
      if (wrBase) begin
        baseHi  <= regWrData[31:4];
        baseSel <= regWrData[0];
      end
      if (wrLctl)  lastIdx  <= regWrData[24 +: IDX_W];
      if (wrStage) stageIdx <= regWrData[IDX_W-1:0];
    end
  end

  // current entry index, owned by the sequencer while running
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curIdx <= '0;
    end else if (strobe.idxWrap) begin
      curIdx <= '0;
    end else if (strobe.idxStep) begin
      curIdx <= curIdx + 1'b1;
    end else if (wrLctl && regWrData[PTR_RESET_BIT] && !chanEn) begin
      curIdx <= '0;
    end
  end

  // channel control: flags only clear by software, set by hardware
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chanEn       <= 1'b0;
      xferEndFlag  <= 1'b0;
      irqEn        <= 1'b0;
      stageEndFlag <= 1'b0;
      stageIrqEn   <= 1'b0;
      reloadEn     <= '0;
      listEn       <= 1'b0;
      modeSel      <= MODE_DIRECT;
    end else begin
      if (wrCtl) begin
        chanEn       <= regWrData[0];
        xferEndFlag  <= xferEndFlag & regWrData[1];
        irqEn        <= regWrData[2];
        stageEndFlag <= stageEndFlag & regWrData[3];
        stageIrqEn   <= regWrData[4];
        reloadEn     <= regWrData[7:5];
        listEn       <= regWrData[8];
        modeSel      <= runMode_e'(regWrData[10:9]);
      end
      if (strobe.setStageEnd) stageEndFlag <= 1'b1;
      if (strobe.setXferEnd) begin
        xferEndFlag <= 1'b1;
        chanEn      <= 1'b0;
      end
    end
  end

  assign listMode    = listEn && baseSel &&
                       ((modeSel == MODE_ONCE) || (modeSel == MODE_ENDLESS));
  assign listEndless = listMode && (modeSel == MODE_ENDLESS);
  assign atLast      = (curIdx == lastIdx);
  assign atStage     = (curIdx == stageIdx);

  assign memAddr = {baseHi, 4'b0000} + (32'(curIdx) << 4) + (32'(strobe.wordSel) << 2);
  assign mvSrc   = wordVal[0];
  assign mvDst   = wordVal[1];
  assign mvCount = wordVal[2][CNT_W-1:0];
  assign irq     = (xferEndFlag && irqEn) || (stageEndFlag && stageIrqEn);

  always_comb begin
    regRdData = '0;
    case (regAddr)
      ADDR_SRC:   regRdData = wordVal[0];
      ADDR_DST:   regRdData = wordVal[1];
      ADDR_CNT:   regRdData = wordVal[2];
      ADDR_LBASE: regRdData = {baseHi, 3'b000, baseSel};
      ADDR_LCTRL: regRdData = {8'(lastIdx), 8'(curIdx), 16'h0000};
      ADDR_STAGE: regRdData = 32'(stageIdx);
      ADDR_CHCTL: regRdData = {21'd0, modeSel, listEn, reloadEn, stageIrqEn,
                               stageEndFlag, irqEn, xferEndFlag, chanEn};
      default:    regRdData = '0;
    endcase
  end

endmodule

// File: rtl/dlseq_ctrl.sv
`timescale 1ns/1ps
module dlseq_ctrl
  import dlseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       chanEn,
  input  logic       xferEndFlag,
  input  logic       listMode,
  input  logic       listEndless,
  input  logic       atLast,
  input  logic       atStage,
  input  logic       memRvalid,
  input  logic       mvDone,
  output seqStrobe_t strobe,
  output logic       memReq,
  output logic       mvStart
);

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_KICK, ST_WAIT} seqState_e;

  seqState_e state;
  logic [1:0] wordSel;
  logic       opDone;
  logic       runOver;

  assign opDone  = (state == ST_WAIT) && mvDone && chanEn;
  assign runOver = !listMode || (atLast && !listEndless);

  always_comb begin
    strobe = '0;
    strobe.wordSel = wordSel;
    for (int w = 0; w < WORDS_PER_ENTRY; w++) begin
      strobe.loadVec[w] = (state == ST_FETCH) && chanEn && memRvalid && (wordSel == 2'(w));
    end
    strobe.setXferEnd  = opDone && runOver;
    strobe.setStageEnd = opDone && listMode && atStage;
    strobe.idxStep     = opDone && listMode && !atLast;
    strobe.idxWrap     = opDone && listEndless && atLast;
  end

  assign memReq  = (state == ST_FETCH) && chanEn;
  assign mvStart = (state == ST_KICK) && chanEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      wordSel <= '0;
    end else if (!chanEn) begin
      state   <= ST_IDLE;
      wordSel <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          wordSel <= '0;
          if (!xferEndFlag) state <= listMode ? ST_FETCH : ST_KICK;
        end
        ST_FETCH: begin
          if (memRvalid) begin
            if (wordSel == 2'(WORDS_PER_ENTRY - 1)) state <= ST_KICK;
            else wordSel <= wordSel + 1'b1;
          end
        end
        ST_KICK: state <= ST_WAIT;
        ST_WAIT: begin
          if (mvDone) begin
            wordSel <= '0;
            state   <= runOver ? ST_IDLE : ST_FETCH;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dlist_dma_seq.sv
`timescale 1ns/1ps
module dlist_dma_seq
  import dlseq_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [2:0]       regAddr,
  input  logic [31:0]      regWrData,
  output logic [31:0]      regRdData,
  output logic             memReq,
  output logic [31:0]      memAddr,
  input  logic [31:0]      memRdata,
  input  logic             memRvalid,
  output logic             mvStart,
  output logic [31:0]      mvSrc,
  output logic [31:0]      mvDst,
  output logic [CNT_W-1:0] mvCount,
  input  logic             mvDone,
  output logic             irq
);

  seqStrobe_t strobe;
  logic chanEn, xferEndFlag, stageEndFlag;
  logic listMode, listEndless, atLast, atStage;

  dlseq_regs #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .strobe(strobe), .memRdata(memRdata), .memAddr(memAddr),
    .mvSrc(mvSrc), .mvDst(mvDst), .mvCount(mvCount),
    .chanEn(chanEn), .xferEndFlag(xferEndFlag), .stageEndFlag(stageEndFlag),
    .listMode(listMode), .listEndless(listEndless),
    .atLast(atLast), .atStage(atStage), .irq(irq)
  );

  dlseq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .chanEn(chanEn), .xferEndFlag(xferEndFlag),
    .listMode(listMode), .listEndless(listEndless),
    .atLast(atLast), .atStage(atStage),
    .memRvalid(memRvalid), .mvDone(mvDone),
    .strobe(strobe), .memReq(memReq), .mvStart(mvStart)
  );

endmodule

// File: rtl/dlist_dma_seq_chk.sv
`timescale 1ns/1ps
module dlist_dma_seq_chk (
  input logic        clk,
  input logic        rstN,
  input logic        memReq,
  input logic [31:0] memAddr,
  input logic        mvStart,
  input logic        irq,
  input logic        chanEn,
  input logic        xferEndFlag,
  input logic        stageEndFlag,
  input logic        listEndless
);

  assert_fetch_word_R3: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (memAddr[1:0] == 2'b00) && (memAddr[3:2] != 2'b11));

  assert_start_pulse_R13: assert property (@(posedge clk) disable iff (!rstN)
    mvStart |=> !mvStart);

  assert_no_overlap_R13: assert property (@(posedge clk) disable iff (!rstN)
    !(memReq && mvStart));

  assert_end_disables_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(xferEndFlag) |-> !chanEn);

  assert_endless_no_end_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(xferEndFlag) |-> !$past(listEndless));

  assert_halt_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    !chanEn |-> (!memReq && !mvStart));

  assert_irq_source_R7: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (xferEndFlag || stageEndFlag));

endmodule

bind dlist_dma_seq dlist_dma_seq_chk u_chk (
  .clk(clk), .rstN(rstN), .memReq(memReq), .memAddr(memAddr),
  .mvStart(mvStart), .irq(irq), .chanEn(chanEn), .xferEndFlag(xferEndFlag),
  .stageEndFlag(stageEndFlag), .listEndless(listEndless)
);

// File: tb/dlist_dma_seq_tb.sv
`timescale 1ns/1ps
module dlist_dma_seq_tb;
  import dlseq_pkg::*;

  localparam int CNT_W = 24;
  localparam logic [31:0] BASE = 32'h0000_8000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [2:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic memReq, mvStart, irq;
  logic [31:0] memAddr, mvSrc, mvDst;
  logic [31:0] memRdata = '0;
  logic memRvalid = 1'b0;
  logic [CNT_W-1:0] mvCount;
  logic mvDone = 1'b0;

  always #2.5 clk = ~clk;

  dlist_dma_seq #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .memReq(memReq),
    .memAddr(memAddr), .memRdata(memRdata), .memRvalid(memRvalid),
    .mvStart(mvStart), .mvSrc(mvSrc), .mvDst(mvDst), .mvCount(mvCount),
    .mvDone(mvDone), .irq(irq)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  task automatic checkEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] memWord(input logic [31:0] a);
    logic [31:0] k;
    k = (a - BASE) >> 4;
    case (a[3:2])
      2'd0:    memWord = 32'h1000_0000 + k * 32'h40;
      2'd1:    memWord = 32'h2000_0000 + k * 32'h40;
      2'd2:    memWord = k + 32'd7;
      default: memWord = 32'hBAD0_0000;
    endcase
  endfunction

  function automatic logic [31:0] ctl(input logic [1:0] mode, input logic ie, input logic sie,
                                      input logic [2:0] rpt, input logic le, input logic en);
    ctl = {21'd0, mode, le, rpt, sie, 1'b0, ie, 1'b0, en};
  endfunction

  // memory model: one response per request, one cycle later
  int reqCount = 0;
  always @(negedge clk) begin
    if (memReq && !memRvalid) begin
      memRvalid = 1'b1;
      memRdata  = memWord(memAddr);
      reqCount++;
    end else begin
      memRvalid = 1'b0;
    end
  end

  // data mover model with expectation checks
  int starts = 0;
  int listBase = 0;
  int expN = 1;
  bit expList = 0;
  bit fixSrc = 0;
  logic [31:0] fixVal = '0, dirSrc = '0, dirDst = '0, dirCnt = '0;
  int doneCnt = 0;
  bit prevStart = 0;
  always @(negedge clk) begin
    mvDone = 1'b0;
    if (doneCnt > 0) begin
      doneCnt--;
      if (doneCnt == 0) mvDone = 1'b1;
    end
    if (mvStart) begin
      checkEq("R13 start is a single-cycle pulse", 32'(prevStart), 32'd0);
      if (expList) begin
        automatic int k = (starts - listBase) % expN;
        automatic logic [31:0] ea = BASE + 32'(k) * 32'd16;
        checkEq(fixSrc ? "R10 held source" : "R4 entry source", mvSrc,
                fixSrc ? fixVal : memWord(ea));
        checkEq("R4 entry destination", mvDst, memWord(ea + 32'd4));
        checkEq("R4 entry count", 32'(mvCount), memWord(ea + 32'd8));
      end else begin
        checkEq("R2 direct source", mvSrc, dirSrc);
        checkEq("R2 direct destination", mvDst, dirDst);
        checkEq("R2 direct count", 32'(mvCount), dirCnt);
      end
      starts++;
      doneCnt = 3;
    end
    prevStart = mvStart;
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic waitIdle(input string tag);
    logic [31:0] v;
    bit idle = 0;
    for (int i = 0; i < 3000 && !idle; i++) begin
      rd(ADDR_CHCTL, v);
      idle = !v[0];
    end
    checkEq({tag, " channel reaches idle"}, 32'(idle), 32'd1);
  endtask

  // mode, entries, stage, irqEn, stageIrqEn | expected starts, stage flag, irq
  localparam logic [29:0] VEC [5] = '{
    {2'b01, 8'd1, 8'd0, 1'b1, 1'b0, 8'd1, 1'b1, 1'b1},
    {2'b01, 8'd4, 8'd2, 1'b0, 1'b1, 8'd4, 1'b1, 1'b1},
    {2'b01, 8'd3, 8'd7, 1'b1, 1'b1, 8'd3, 1'b0, 1'b1},
    {2'b01, 8'd5, 8'd4, 1'b0, 1'b0, 8'd5, 1'b1, 1'b0},
    {2'b01, 8'd2, 8'd0, 1'b0, 1'b1, 8'd2, 1'b1, 1'b1}
  };

  initial begin
    logic [31:0] v;
    int s0, r0;

    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    for (int a = 0; a < 7; a++) begin
      rd(3'(a), v);
      checkEq("R1 register reset value", v, 32'd0);
    end
    checkEq("R1 irq low", 32'(irq), 32'd0);
    checkEq("R1 memReq low", 32'(memReq), 32'd0);
    checkEq("R1 mvStart low", 32'(mvStart), 32'd0);

    // R2: direct run, count masked to CNT_W bits
    wr(ADDR_SRC, 32'h1111_2220);
    wr(ADDR_DST, 32'h3333_4440);
    wr(ADDR_CNT, 32'h12AB_CDEF);
    rd(ADDR_CNT, v);
    checkEq("R2 count width", v, 32'h00AB_CDEF);
    dirSrc = 32'h1111_2220; dirDst = 32'h3333_4440; dirCnt = 32'h00AB_CDEF;
    expList = 0; s0 = starts; r0 = reqCount;
    wr(ADDR_CHCTL, ctl(2'b00, 1, 0, 3'b000, 0, 1));
    waitIdle("R2");
    checkEq("R2 one start", 32'(starts - s0), 32'd1);
    checkEq("R2 no fetch", 32'(reqCount - r0), 32'd0);
    rd(ADDR_CHCTL, v);
    checkEq("R2 end flag set", 32'(v[1]), 32'd1);
    checkEq("R7 irq on end", 32'(irq), 32'd1);
    wr(ADDR_CHCTL, ctl(2'b00, 1, 0, 3'b000, 0, 0));
    checkEq("R8 irq drops after clear", 32'(irq), 32'd0);
    rd(ADDR_CHCTL, v);
    checkEq("R8 end flag cleared", 32'(v[1]), 32'd0);

    // R8: writing 1 to flags has no effect
    wr(ADDR_CHCTL, 32'h0000_000A);
    rd(ADDR_CHCTL, v);
    checkEq("R8 flags ignore write of one", {30'd0, v[3], v[1]}, 32'd0);
    checkEq("R8 irq stays low", 32'(irq), 32'd0);

    // R3: base register keeps bits 31:4 and the select bit
    wr(ADDR_LBASE, BASE | 32'h5);
    rd(ADDR_LBASE, v);
    checkEq("R3 base readback", v, BASE | 32'h1);

    // single-pass table
    for (int e = 0; e < 5; e++) begin
      automatic logic [29:0] t = VEC[e];
      automatic logic [7:0] n = t[27:20];
      wr(ADDR_LCTRL, {n - 8'd1, 8'h00, 16'h8000});
      wr(ADDR_STAGE, 32'(t[19:12]));
      expList = 1; fixSrc = 0; expN = int'(n); listBase = starts; r0 = reqCount;
      wr(ADDR_CHCTL, ctl(t[29:28], t[11], t[10], 3'b111, 1, 1));
      waitIdle("R4");
      checkEq("R4 starts per entry", 32'(starts - listBase), 32'(t[9:2]));
      checkEq("R3 three reads per entry", 32'(reqCount - r0), 32'(n) * 32'd3);
      rd(ADDR_CHCTL, v);
      checkEq("R4 end flag after last", 32'(v[1]), 32'd1);
      checkEq("R6 stage flag", 32'(v[3]), 32'(t[1]));
      checkEq("R7 irq", 32'(irq), 32'(t[0]));
      rd(ADDR_LCTRL, v);
      checkEq("R4 current index at last", 32'(v[23:16]), 32'(n - 8'd1));
      wr(ADDR_CHCTL, 32'd0);
      checkEq("R8 irq clear", 32'(irq), 32'd0);
    end

    // R10: source reload disabled
    wr(ADDR_SRC, 32'hCAFE_0000);
    wr(ADDR_LCTRL, {8'd1, 8'h00, 16'h8000});
    wr(ADDR_STAGE, 32'd9);
    expList = 1; fixSrc = 1; fixVal = 32'hCAFE_0000; expN = 2; listBase = starts;
    wr(ADDR_CHCTL, ctl(2'b01, 0, 0, 3'b110, 1, 1));
    waitIdle("R10");
    rd(ADDR_SRC, v);
    checkEq("R10 source kept", v, 32'hCAFE_0000);
    rd(ADDR_DST, v);
    checkEq("R10 destination reloaded", v, memWord(BASE + 32'd20));
    wr(ADDR_CHCTL, 32'd0);
    fixSrc = 0;

    // R12: pointer reset; written index bits ignored
    wr(ADDR_LCTRL, {8'd1, 8'h55, 16'h0000});
    rd(ADDR_LCTRL, v);
    checkEq("R12 index not writable", 32'(v[23:16]), 32'd1);
    checkEq("R12 last index written", 32'(v[31:24]), 32'd1);
    wr(ADDR_LCTRL, {8'd1, 8'h00, 16'h8000});
    rd(ADDR_LCTRL, v);
    checkEq("R12 pointer reset", 32'(v[23:16]), 32'd0);

    // R11: list mode without list enable runs direct
    wr(ADDR_SRC, 32'h0000_4440);
    wr(ADDR_DST, 32'h0000_5550);
    wr(ADDR_CNT, 32'h0000_0033);
    dirSrc = 32'h0000_4440; dirDst = 32'h0000_5550; dirCnt = 32'h33;
    expList = 0; s0 = starts; r0 = reqCount;
    wr(ADDR_CHCTL, ctl(2'b01, 0, 0, 3'b111, 0, 1));
    waitIdle("R11");
    checkEq("R11 single direct start", 32'(starts - s0), 32'd1);
    checkEq("R11 no memory request", 32'(reqCount - r0), 32'd0);
    wr(ADDR_CHCTL, 32'd0);

    // R5/R6/R8/R9: endless run, stage service, halt
    wr(ADDR_LCTRL, {8'd2, 8'h00, 16'h8000});
    wr(ADDR_STAGE, 32'd1);
    expList = 1; expN = 3; listBase = starts;
    wr(ADDR_CHCTL, ctl(2'b10, 1, 1, 3'b111, 1, 1));
    begin
      bit seen = 0;
      for (int i = 0; i < 2000 && !seen; i++) begin
        rd(ADDR_CHCTL, v);
        seen = v[3];
      end
      checkEq("R6 stage flag in endless run", 32'(seen), 32'd1);
    end
    checkEq("R6 stage after second entry", 32'(starts - listBase), 32'd2);
    checkEq("R7 irq on stage", 32'(irq), 32'd1);
    wr(ADDR_STAGE, 32'd0);
    wr(ADDR_CHCTL, ctl(2'b10, 1, 1, 3'b111, 1, 1));
    checkEq("R8 irq low after stage clear", 32'(irq), 32'd0);
    rd(ADDR_CHCTL, v);
    checkEq("R8 channel still enabled", 32'(v[0]), 32'd1);
    for (int i = 0; i < 3000 && (starts - listBase) < 8; i++) @(negedge clk);
    checkEq("R5 wrapped past last entry", 32'((starts - listBase) >= 8), 32'd1);
    rd(ADDR_CHCTL, v);
    checkEq("R5 no end flag", 32'(v[1]), 32'd0);
    checkEq("R5 still running", 32'(v[0]), 32'd1);
    checkEq("R6 stage 0 hit after wrap", 32'(v[3]), 32'd1);
    wr(ADDR_CHCTL, 32'd0);
    s0 = starts; r0 = reqCount;
    repeat (40) @(negedge clk);
    checkEq("R9 no start after halt", 32'(starts - s0), 32'd0);
    checkEq("R9 no fetch after halt", 32'(reqCount - r0), 32'd0);
    checkEq("R9 irq low after halt", 32'(irq), 32'd0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule